// File: doc/BRIEF.md
# Coefficient Token and Trailing-Sign Encoder

This block turns the per-block summary of a residual transform block into its first two bitstream fields. Each cycle it can accept one symbol: the count of nonzero coefficients (TC), the count of trailing ±1 coefficients (T1, at most three), the signs of those trailing ones, and a context value nC. The context value is derived from the neighbouring blocks' nonzero counts and picks the code used for the token. The block returns the token codeword with its length, and all trailing-one sign bits with their length. Both results appear together, one clock after the symbol is accepted.

There are five code choices. A context of eight or more uses a fixed six-bit code formed by arithmetic. The three low-context ranges and the chroma-DC context (nC = -1) each have their own sub-table. All four sub-tables are addressed at the same time from {TC, T1}. The context decode enables exactly one of them, and the disabled ones contribute zero to an OR merge. The low-context sub-tables hold a generated code family that is filled in at elaboration. The chroma-DC sub-table is written out in full.

Top module: `coeff_token_enc`

## Requirements
- R1: While reset is held and after it is released, with no symbol accepted yet, outValid, tokenCode, tokenLen, signCode and signLen are all zero.
- R2: A symbol presented with inValid high at a rising edge produces its results after that edge, with outValid high for exactly that one cycle. outValid is low in the cycle after an edge where inValid was low.
- R3: While inValid is low, tokenCode, tokenLen, signCode and signLen hold their last values, whatever the other inputs do.
- R4: For nC of 8 or more, tokenLen is 6. tokenCode is 3 when TC is 0. Otherwise tokenCode is the low six bits of (TC-1)*4+T1, which is the concatenation of TC-1 above the two T1 bits.
- R5: For nC in 0..1, 2..3 and 4..7, let k be 0, 1 and 2 respectively, and let r = 4*TC - 3*T1. Then tokenCode = r + 2^k, right-aligned with zeros above it. tokenLen = 2*floor(log2(r + 2^k)) + 1 - k. This covers TC up to 16.
- R6: For nC = -1 (TC 0..4), the (code, length) pair for each TC/T1 is as follows. TC0: (1,2). TC1: T1=0 (7,6), T1=1 (1,1). TC2: T1=0 (4,6), T1=1 (6,6), T1=2 (1,3). TC3: T1=0 (3,6), T1=1 (3,7), T1=2 (2,7), T1=3 (5,6). TC4: T1=0 (2,6), T1=1 (3,8), T1=2 (2,8), T1=3 (0,7).
- R7: signArr bit i is the sign of the i-th trailing one, with bit 0 being the highest-frequency one and 1 meaning negative. signLen equals T1. signCode places sign 0 at bit T1-1 and the following signs in the lower bits, in order. Bits of signCode at and above T1 are zero, and signArr bits at index T1 or above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Symbol present this cycle |
| nC | input | 6 | Signed context value; -1 selects chroma DC |
| totalCoeff | input | 5 | Nonzero coefficient count, 0..16 |
| trailOnes | input | 2 | Trailing-one count, 0..3, not above totalCoeff |
| signArr | input | 3 | Trailing-one signs, bit 0 first, 1 = negative |
| outValid | output | 1 | Results valid this cycle |
| tokenCode | output | 16 | Token codeword, right-aligned |
| tokenLen | output | 5 | Token codeword length in bits |
| signCode | output | 3 | Sign bits, first sign at bit signLen-1 |
| signLen | output | 2 | Number of sign bits |

## Verification
The hardest cases to reach are the edges of the context ranges and the sub-table corners. These include nC at 1/2, 3/4, 7/8 and -1, TC = 16 with three trailing ones, and TC = 0 in every table. Uniform random inputs seldom hit these cases, so a directed pass steps through every context boundary and all fourteen chroma-DC entries. Random legal symbols then follow, with nC drawn over -1..16 and T1 capped by TC. The unused signArr bits are randomised so that the bench can show they never leak into signCode. Idle cycles with changed inputs check that the outputs hold.

// File: rtl/cte_pkg.sv
package cte_pkg;
  localparam int CW_W        = 16;
  localparam int LEN_W       = 5;
  localparam int TC_W        = 5;
  localparam int T1_W        = 2;
  localparam int NC_W        = 6;
  localparam int SIGN_W      = 3;
  localparam int ADDR_W      = TC_W + T1_W;
  localparam int ROM_DEPTH   = 2 ** ADDR_W;
  localparam int LUMA_TABLES = 3;
  localparam int SUB_COUNT   = LUMA_TABLES + 2;
  localparam int FIXED_LEN   = 6;

  localparam logic signed [NC_W-1:0] NC_MID_MIN   = NC_W'(2);
  localparam logic signed [NC_W-1:0] NC_HIGH_MIN  = NC_W'(4);
  localparam logic signed [NC_W-1:0] NC_FIXED_MIN = NC_W'(8);

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [CW_W-1:0]  code;
  } tokEntry_t;

  typedef struct packed {
    logic                   load;
    logic                   useFixed;
    logic                   useChroma;
    logic [LUMA_TABLES-1:0] lumaEn;
  } ctrlStb_t;

  // Generated code family for the low-context sub-tables.
  function automatic tokEntry_t lumaEntry(int unsigned addr, int unsigned k);
    int r;
    int v;
    int n;
    tokEntry_t e;
    r = 4 * int'(addr >> T1_W) - 3 * int'(addr & 3);
    if (r < 0) r = 0;
    v = r + (1 << k);
    n = 0;
    for (int b = 0; b < 31; b++) begin
      if ((v >> b) != 0) n = b;
    end
    e.len  = LEN_W'(2 * n + 1 - int'(k));
    e.code = CW_W'(v);
    return e;
  endfunction
endpackage

// File: rtl/cte_ctrl.sv
module cte_ctrl
  import cte_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic signed [NC_W-1:0] nC,
  output ctrlStb_t               stb,
  output logic                   outValid
);

  // Context decode: one strobe per sub-table.
  always_comb begin
    stb      = '0;
    stb.load = inValid;
    if (nC[NC_W-1]) begin
      stb.useChroma = 1'b1;
    end else if (nC >= NC_FIXED_MIN) begin
      stb.useFixed = 1'b1;
    end else if (nC >= NC_HIGH_MIN) begin
      stb.lumaEn[2] = 1'b1;
    end else if (nC >= NC_MID_MIN) begin
      stb.lumaEn[1] = 1'b1;
    end else begin
      stb.lumaEn[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/cte_datapath.sv
module cte_datapath
  import cte_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [TC_W-1:0]   totalCoeff,
  input  logic [T1_W-1:0]   trailOnes,
  input  logic [SIGN_W-1:0] signArr,
  output logic [CW_W-1:0]   tokenCode,
  output logic [LEN_W-1:0]  tokenLen,
  output logic [SIGN_W-1:0] signCode,
  output logic [T1_W-1:0]   signLen
);

  logic [ADDR_W-1:0] addr;
  assign addr = {totalCoeff, trailOnes};

  tokEntry_t lumaRom [LUMA_TABLES][ROM_DEPTH];
  tokEntry_t subOut  [SUB_COUNT];

  // Low-context sub-tables, filled at elaboration, read in parallel.
  for (genvar g = 0; g < LUMA_TABLES; g++) begin : g_luma
    for (genvar e = 0; e < ROM_DEPTH; e++) begin : g_entry
      assign lumaRom[g][e] = lumaEntry(e, g);
    end
    assign subOut[g] = stb.lumaEn[g] ? lumaRom[g][addr] : '0;
  end

  // Chroma-DC sub-table.
  tokEntry_t chromaEnt;
  always_comb begin
    unique case ({totalCoeff[2:0], trailOnes})
      5'b000_00: chromaEnt = '{len: LEN_W'(2), code: CW_W'(1)};
      5'b001_00: chromaEnt = '{len: LEN_W'(6), code: CW_W'(7)};
      5'b001_01: chromaEnt = '{len: LEN_W'(1), code: CW_W'(1)};
      5'b010_00: chromaEnt = '{len: LEN_W'(6), code: CW_W'(4)};
      5'b010_01: chromaEnt = '{len: LEN_W'(6), code: CW_W'(6)};
      5'b010_10: chromaEnt = '{len: LEN_W'(3), code: CW_W'(1)};
      5'b011_00: chromaEnt = '{len: LEN_W'(6), code: CW_W'(3)};
      5'b011_01: chromaEnt = '{len: LEN_W'(7), code: CW_W'(3)};
      5'b011_10: chromaEnt = '{len: LEN_W'(7), code: CW_W'(2)};
      5'b011_11: chromaEnt = '{len: LEN_W'(6), code: CW_W'(5)};
      5'b100_00: chromaEnt = '{len: LEN_W'(6), code: CW_W'(2)};
      5'b100_01: chromaEnt = '{len: LEN_W'(8), code: CW_W'(3)};
      5'b100_10: chromaEnt = '{len: LEN_W'(8), code: CW_W'(2)};
      5'b100_11: chromaEnt = '{len: LEN_W'(7), code: CW_W'(0)};
      default:   chromaEnt = '0;
    endcase
  end
  assign subOut[LUMA_TABLES] = stb.useChroma ? chromaEnt : '0;

  // Fixed-length path: arithmetic instead of a table.
  tokEntry_t fixedEnt;
  logic [TC_W-1:0] tcLess;
  assign tcLess = totalCoeff - TC_W'(1);
  always_comb begin
    fixedEnt.len = LEN_W'(FIXED_LEN);
    if (totalCoeff == '0) fixedEnt.code = CW_W'(3);
    else                  fixedEnt.code = CW_W'({tcLess[FIXED_LEN-T1_W-1:0], trailOnes});
  end
  assign subOut[LUMA_TABLES+1] = stb.useFixed ? fixedEnt : '0;

  tokEntry_t merged;
  always_comb begin
    merged = '0;
    for (int i = 0; i < SUB_COUNT; i++) merged = merged | subOut[i];
  end

  // All trailing-one signs packed in one step.
  logic [SIGN_W-1:0] signNext;
  always_comb begin
    signNext = '0;
    for (int i = 0; i < SIGN_W; i++) begin
      if (i < int'(trailOnes)) signNext[int'(trailOnes) - 1 - i] = signArr[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tokenCode <= '0;
      tokenLen  <= '0;
      signCode  <= '0;
      signLen   <= '0;
    end else if (stb.load) begin
      tokenCode <= merged.code;
      tokenLen  <= merged.len;
      signCode  <= signNext;
      signLen   <= trailOnes;
    end
  end

  a_r2_one_table: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> $onehot({stb.useFixed, stb.useChroma, stb.lumaEn}));
  a_r4_fixed_len: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.useFixed) |=> tokenLen == LEN_W'(FIXED_LEN));
  a_r7_sign_clean: assert property (@(posedge clk) disable iff (!rstN)
    (signCode >> signLen) == '0);

endmodule

// File: rtl/coeff_token_enc.sv
module coeff_token_enc
  import cte_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic signed [NC_W-1:0] nC,
  input  logic [TC_W-1:0]        totalCoeff,
  input  logic [T1_W-1:0]        trailOnes,
  input  logic [SIGN_W-1:0]      signArr,
  output logic                   outValid,
  output logic [CW_W-1:0]        tokenCode,
  output logic [LEN_W-1:0]       tokenLen,
  output logic [SIGN_W-1:0]      signCode,
  output logic [T1_W-1:0]        signLen
);

  ctrlStb_t stb;

  cte_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .nC(nC),
    .stb(stb), .outValid(outValid)
  );

  cte_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .totalCoeff(totalCoeff), .trailOnes(trailOnes), .signArr(signArr),
    .tokenCode(tokenCode), .tokenLen(tokenLen),
    .signCode(signCode), .signLen(signLen)
  );

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(tokenCode) && $stable(tokenLen) &&
                  $stable(signCode) && $stable(signLen)));
  a_r7_sign_len: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> signLen == $past(trailOnes));
  a_r2_len_present: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> tokenLen != '0);

endmodule

// File: tb/coeff_token_enc_tb.sv
module coeff_token_enc_tb;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic signed [5:0] nC = '0;
  logic [4:0]        totalCoeff = '0;
  logic [1:0]        trailOnes = '0;
  logic [2:0]        signArr = '0;
  logic              outValid;
  logic [15:0]       tokenCode;
  logic [4:0]        tokenLen;
  logic [2:0]        signCode;
  logic [1:0]        signLen;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  coeff_token_enc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .nC(nC),
    .totalCoeff(totalCoeff), .trailOnes(trailOnes), .signArr(signArr),
    .outValid(outValid), .tokenCode(tokenCode), .tokenLen(tokenLen),
    .signCode(signCode), .signLen(signLen)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expTok(input int nc, input int tc, input int t1,
                                 output int code, output int len, output string req);
    if (nc < 0) begin
      req = "R6";
      case (tc * 4 + t1)
        0:  begin code = 1; len = 2; end
        4:  begin code = 7; len = 6; end
        5:  begin code = 1; len = 1; end
        8:  begin code = 4; len = 6; end
        9:  begin code = 6; len = 6; end
        10: begin code = 1; len = 3; end
        12: begin code = 3; len = 6; end
        13: begin code = 3; len = 7; end
        14: begin code = 2; len = 7; end
        15: begin code = 5; len = 6; end
        16: begin code = 2; len = 6; end
        17: begin code = 3; len = 8; end
        18: begin code = 2; len = 8; end
        19: begin code = 0; len = 7; end
        default: begin code = -1; len = -1; end
      endcase
    end else if (nc >= 8) begin
      req = "R4";
      len = 6;
      code = (tc == 0) ? 3 : (((tc - 1) * 4 + t1) % 64);
    end else begin
      int k;
      int v;
      int nb;
      req = "R5";
      k = (nc >= 4) ? 2 : (nc >= 2) ? 1 : 0;
      v = 4 * tc - 3 * t1 + (1 << k);
      nb = 0;
      while ((v >> nb) != 0) nb++;
      code = v;
      len = 2 * nb - 1 - k;
    end
  endfunction

  function automatic int expSign(input int t1, input int sg);
    int s = 0;
    for (int i = 0; i < t1; i++) s = (s << 1) | ((sg >> i) & 1);
    return s;
  endfunction

  task automatic runSym(input int nc, input int tc, input int t1, input int sg);
    int code;
    int len;
    string req;
    @(negedge clk);
    inValid = 1'b1;
    nC = 6'(nc);
    totalCoeff = 5'(tc);
    trailOnes = 2'(t1);
    signArr = 3'(sg);
    @(negedge clk);
    inValid = 1'b0;
    expTok(nc, tc, t1, code, len, req);
    check("R2 outValid", int'(outValid), 1);
    check({req, " code"}, int'(tokenCode), code);
    check({req, " len"}, int'(tokenLen), len);
    check("R7 signCode", int'(signCode), expSign(t1, sg));
    check("R7 signLen", int'(signLen), t1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outValid", int'(outValid), 0);
    check("R1 tokenCode", int'(tokenCode), 0);
    check("R1 tokenLen", int'(tokenLen), 0);
    check("R1 signCode", int'(signCode), 0);
    check("R1 signLen", int'(signLen), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(tokenLen), 0);

    // Context boundaries and corners (R4, R5)
    runSym(1, 0, 0, 0);
    runSym(2, 0, 0, 0);
    runSym(3, 16, 3, 7);
    runSym(4, 16, 0, 0);
    runSym(7, 5, 2, 3);
    runSym(8, 0, 0, 0);
    runSym(8, 1, 1, 1);
    runSym(16, 16, 3, 5);
    runSym(0, 16, 3, 2);
    // R6: every chroma-DC entry
    for (int tc = 0; tc <= 4; tc++)
      for (int t1 = 0; t1 <= ((tc < 3) ? tc : 3); t1++)
        runSym(-1, tc, t1, 6);

    // R3 and R2: idle cycle with changed inputs
    runSym(5, 9, 2, 1);
    @(negedge clk);
    nC = 6'(12);
    totalCoeff = 5'd3;
    trailOnes = 2'd0;
    signArr = 3'd7;
    @(negedge clk);
    check("R2 outValid low when idle", int'(outValid), 0);
    check("R3 tokenCode held", int'(tokenCode), 4 * 9 - 6 + 4);
    check("R3 tokenLen held", int'(tokenLen), 9);
    check("R3 signCode held", int'(signCode), 2);
    check("R3 signLen held", int'(signLen), 2);

    // Random legal symbols
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      int nc;
      int tc;
      int t1;
      int mx;
      nc = int'($urandom_range(0, 17)) - 1;
      tc = (nc < 0) ? int'($urandom_range(0, 4)) : int'($urandom_range(0, 16));
      mx = (tc < 3) ? tc : 3;
      t1 = int'($urandom_range(0, mx));
      runSym(nc, tc, t1, int'($urandom_range(0, 7)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule